// File: doc/BRIEF.md
# Packet-VM Integer ALU Datapath

This block executes the integer arithmetic group of a 64-bit register virtual machine. One operation per handshake enters with an already-decoded 4-bit operation code, a source-select bit, a class-width bit, the 16-bit offset field, the 32-bit immediate field and the current values of the destination and source registers. The block computes the new destination value in one cycle and presents it in an output register together with an illegal-instruction flag. Division and modulo belong to a separate unit and are flagged here as unsupported.

The input side is a valid/ready pair. An operation is taken on a rising clock edge where `in_valid` and `in_ready` are both high. The output register holds a result while `out_valid` is high and `out_ready` is low. A new operation can be accepted only when the output register is empty or is being drained in the same cycle, so `in_ready` equals `!out_valid || out_ready`. The result appears on the cycle after acceptance. The parameter `HOST_BIG_ENDIAN` sets the byte order that the byte-order conversion group treats as native.

Top module: `vm_alu`

## Requirements
- R1: `in_ready` is `!out_valid || out_ready`. An operation accepted at an edge makes `out_valid` high after that edge, with its result on `out_data`/`out_illegal`. A drained output with no new operation makes `out_valid` low.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_illegal` hold their values, and no new operation is taken.
- R3: After reset, `out_valid` is 0 and `in_ready` is 1.
- R4: With `in_use_reg`=0 the operand is the immediate. In 64-bit class (`in_wide`=1) the immediate is first sign-extended from bit 31. With `in_use_reg`=1 the operand is `in_src`.
- R5: In 32-bit class (`in_wide`=0), both operands are truncated to 32 bits and result bits 63:32 are zero. The byte-order group (code 0xd) is the exception.
- R6: The codes are ADD 0x0, SUB 0x1, MUL 0x2, OR 0x4, AND 0x5 and XOR 0xa. They compute dst+op, dst-op, the low half of dst*op, dst|op, dst&op and dst^op, and they wrap on overflow.
- R7: LSH 0x6, RSH 0x7 (logical) and ARSH 0xc (sign-filling from bit 63, or from bit 31 in 32-bit class) shift by the operand masked with 0x3F in 64-bit class and 0x1F in 32-bit class.
- R8: NEG 0x8 gives 0-dst with `in_use_reg`=0. With `in_use_reg`=1 it is illegal.
- R9: MOV 0xb with offset 0 copies the operand. An offset of 8, 16 or 32 with `in_use_reg`=1 sign-extends that many low bits of `in_src`. In 32-bit class only 8 and 16 are allowed, and the 32-bit result is zero-extended. Any other nonzero offset, or any nonzero offset with `in_use_reg`=0, is illegal.
- R10: For byte-order op 0xd in 32-bit class, the immediate picks a width of 16, 32 or 64. `in_use_reg`=0 means little-endian and 1 means big-endian. When the selected order equals the host order, the low width bits are zero-extended. Otherwise those bytes are reversed and zero-extended. With the default little-endian host, little-endian means truncation.
- R11: For op 0xd in 64-bit class, the low width bytes are always reversed and zero-extended. Setting `in_use_reg`=1 there is illegal, and any immediate other than 16, 32 or 64 is illegal in either class.
- R12: Codes 0x3, 0x9, 0xe and 0xf, and a nonzero offset on any op other than MOV, are illegal. Every illegal operation gives `out_illegal`=1 and `out_data` equal to `in_dst` unchanged. Legal operations give `out_illegal`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 4 | Decoded operation code |
| in_use_reg | input | 1 | 1: register operand, 0: immediate (byte order select for 0xd) |
| in_wide | input | 1 | 1: 64-bit class, 0: 32-bit class |
| in_offset | input | 16 | Offset field (sign-extension width for MOV) |
| in_imm | input | 32 | Immediate field (swap width for 0xd) |
| in_dst | input | 64 | Destination register value |
| in_src | input | 64 | Source register value |
| out_valid | output | 1 | Result held in output register |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | New destination value |
| out_illegal | output | 1 | Operation was not supported |

## Verification
The hardest case to reach from the ports is a stall with a second operation already waiting. The first result must stay frozen while new operand values sit on the inputs, and the release must drain the old result and take the new one on the same edge. The stimulus holds `out_ready` low for several cycles after one acceptance, changes the inputs during the stall, and then releases. The opposite-host byte-order path is reached by building a second instance with a big-endian host beside the default one and driving both with the same conversion operations.

// File: rtl/vm_alu_pkg.sv
package vm_alu_pkg;
  localparam logic [3:0] OPC_ADD  = 4'h0;
  localparam logic [3:0] OPC_SUB  = 4'h1;
  localparam logic [3:0] OPC_MUL  = 4'h2;
  localparam logic [3:0] OPC_OR   = 4'h4;
  localparam logic [3:0] OPC_AND  = 4'h5;
  localparam logic [3:0] OPC_LSH  = 4'h6;
  localparam logic [3:0] OPC_RSH  = 4'h7;
  localparam logic [3:0] OPC_NEG  = 4'h8;
  localparam logic [3:0] OPC_XOR  = 4'ha;
  localparam logic [3:0] OPC_MOV  = 4'hb;
  localparam logic [3:0] OPC_ARSH = 4'hc;
  localparam logic [3:0] OPC_BORD = 4'hd;
endpackage

// File: rtl/vm_alu_operand.sv
module vm_alu_operand #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 32
) (
  input  logic             use_reg,
  input  logic             wide,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  src,
  output logic [XLEN-1:0]  opnd
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] imm_sx, imm_zx;

  assign imm_sx = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign imm_zx = {{(XLEN-IMM_W){1'b0}}, imm};

  always_comb begin
    if (use_reg) opnd = wide ? src : {{HALF{1'b0}}, src[HALF-1:0]};
    else         opnd = wide ? imm_sx : imm_zx;
  end
endmodule

// File: rtl/vm_alu_swap.sv
module vm_alu_swap #(
  parameter int XLEN            = 64,
  parameter int IMM_W           = 32,
  parameter bit HOST_BIG_ENDIAN = 1'b0
) (
  input  logic [XLEN-1:0]  dst,
  input  logic             wide,
  input  logic             order_sel,
  input  logic [IMM_W-1:0] width_code,
  output logic [XLEN-1:0]  res,
  output logic             bad
);
  localparam int MIN_W = 16;
  localparam int NW    = $clog2(XLEN / MIN_W) + 1;

  logic [NW-1:0][XLEN-1:0] rev_all, trunc_all;

  for (genvar k = 0; k < NW; k++) begin : g_width
    localparam int W  = MIN_W << k;
    localparam int NB = W / 8;
    logic [XLEN-1:0] rev_k;
    always_comb begin
      rev_k = '0;
      for (int i = 0; i < NB; i++) rev_k[8*i +: 8] = dst[8*(NB-1-i) +: 8];
    end
    assign rev_all[k]   = rev_k;
    assign trunc_all[k] = {{(XLEN-W){1'b0}}, dst[W-1:0]};
  end

  logic do_rev;
  assign do_rev = wide | (order_sel != HOST_BIG_ENDIAN);

  always_comb begin
    res = dst;
    bad = 1'b1;
    for (int k = 0; k < NW; k++) begin
      if (width_code == IMM_W'(MIN_W << k)) begin
        res = do_rev ? rev_all[k] : trunc_all[k];
        bad = 1'b0;
      end
    end
    if (wide && order_sel) bad = 1'b1;
  end
endmodule

// File: rtl/vm_alu_core.sv
module vm_alu_core
  import vm_alu_pkg::*;
#(
  parameter int XLEN            = 64,
  parameter int IMM_W           = 32,
  parameter int OFF_W           = 16,
  parameter bit HOST_BIG_ENDIAN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en,
  input  logic [3:0]       op,
  input  logic             use_reg,
  input  logic             wide,
  input  logic [OFF_W-1:0] offset,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  dst,
  input  logic [XLEN-1:0]  src,
  output logic [XLEN-1:0]  res,
  output logic             bad
);
  localparam int HALF = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);

  logic [XLEN-1:0] a, b, swp, r;
  logic [SHW-1:0]  shamt;
  logic [HALF-1:0] ar_half;
  logic            swp_bad, r_bad;

  vm_alu_operand #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opnd (
    .use_reg(use_reg), .wide(wide), .imm(imm), .src(src), .opnd(b)
  );

  vm_alu_swap #(.XLEN(XLEN), .IMM_W(IMM_W), .HOST_BIG_ENDIAN(HOST_BIG_ENDIAN)) u_swap (
    .dst(dst), .wide(wide), .order_sel(use_reg), .width_code(imm),
    .res(swp), .bad(swp_bad)
  );

  assign a       = wide ? dst : {{HALF{1'b0}}, dst[HALF-1:0]};
  assign shamt   = wide ? b[SHW-1:0] : {1'b0, b[SHW-2:0]};
  assign ar_half = $signed(a[HALF-1:0]) >>> shamt[SHW-2:0];

  always_comb begin
    r     = '0;
    r_bad = 1'b0;
    unique case (op)
      OPC_ADD:  r = a + b;
      OPC_SUB:  r = a - b;
      OPC_MUL:  r = a * b;
      OPC_OR:   r = a | b;
      OPC_AND:  r = a & b;
      OPC_XOR:  r = a ^ b;
      OPC_LSH:  r = a << shamt;
      OPC_RSH:  r = a >> shamt;
      OPC_ARSH: r = wide ? XLEN'($signed(a) >>> shamt) : {{HALF{1'b0}}, ar_half};
      OPC_NEG: begin
        r     = '0 - a;
        r_bad = use_reg;
      end
      OPC_MOV: begin
        if (offset == '0) r = b;
        else if (!use_reg) r_bad = 1'b1;
        else if (offset == OFF_W'(8))  r = {{(XLEN-8){src[7]}}, src[7:0]};
        else if (offset == OFF_W'(16)) r = {{(XLEN-16){src[15]}}, src[15:0]};
        else if (offset == OFF_W'(HALF) && wide) r = {{HALF{src[HALF-1]}}, src[HALF-1:0]};
        else r_bad = 1'b1;
      end
      OPC_BORD: begin
        r     = swp;
        r_bad = swp_bad;
      end
      default: r_bad = 1'b1;
    endcase
    if (op != OPC_MOV && offset != '0) r_bad = 1'b1;
  end

  always_comb begin
    bad = r_bad;
    if (r_bad)                      res = dst;
    else if (!wide && op != OPC_BORD) res = {{HALF{1'b0}}, r[HALF-1:0]};
    else                            res = r;
  end

  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !wide && op != OPC_BORD && !bad) |-> (res[XLEN-1:HALF] == '0)); // R5
  AST_BAD_KEEPS_DST: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && bad) |-> (res == dst)); // R12
  AST_NEG_REG_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && op == OPC_NEG && use_reg) |-> bad); // R8
  AST_SWAP_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && op == OPC_BORD && wide && use_reg) |-> bad); // R11
endmodule

// File: rtl/vm_alu.sv
module vm_alu #(
  parameter int XLEN            = 64,
  parameter int IMM_W           = 32,
  parameter int OFF_W           = 16,
  parameter bit HOST_BIG_ENDIAN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_op,
  input  logic             in_use_reg,
  input  logic             in_wide,
  input  logic [OFF_W-1:0] in_offset,
  input  logic [IMM_W-1:0] in_imm,
  input  logic [XLEN-1:0]  in_dst,
  input  logic [XLEN-1:0]  in_src,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_data,
  output logic             out_illegal
);
  logic [XLEN-1:0] core_res;
  logic            core_bad;
  logic            take;

  vm_alu_core #(
    .XLEN(XLEN), .IMM_W(IMM_W), .OFF_W(OFF_W), .HOST_BIG_ENDIAN(HOST_BIG_ENDIAN)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .chk_en(in_valid),
    .op(in_op), .use_reg(in_use_reg), .wide(in_wide), .offset(in_offset),
    .imm(in_imm), .dst(in_dst), .src(in_src), .res(core_res), .bad(core_bad)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_illegal <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_data    <= core_res;
      out_illegal <= core_bad;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_illegal))); // R2
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R1
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R1
endmodule

// File: tb/test_vm_alu.sv
`timescale 1ns/1ps
module test_vm_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic        in_use_reg = 1'b0;
  logic        in_wide = 1'b0;
  logic [15:0] in_offset = '0;
  logic [31:0] in_imm = '0;
  logic [63:0] in_dst = '0;
  logic [63:0] in_src = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        out_illegal;
  logic        be_ready, be_valid, be_illegal;
  logic [63:0] be_data;

  always #2.5 clk = ~clk;

  vm_alu i_vm_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_use_reg(in_use_reg), .in_wide(in_wide), .in_offset(in_offset),
    .in_imm(in_imm), .in_dst(in_dst), .in_src(in_src), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_illegal(out_illegal)
  );

  vm_alu #(.HOST_BIG_ENDIAN(1'b1)) i_vm_alu_be (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(be_ready),
    .in_op(in_op), .in_use_reg(in_use_reg), .in_wide(in_wide), .in_offset(in_offset),
    .in_imm(in_imm), .in_dst(in_dst), .in_src(in_src), .out_valid(be_valid),
    .out_ready(1'b1), .out_data(be_data), .out_illegal(be_illegal)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic        rs;
    logic        wd;
    logic [15:0] off;
    logic [31:0] imm;
    logic [63:0] dst;
    logic [63:0] src;
    logic [63:0] exp;
    logic        ill;
    logic [7:0]  req;
  } vec_t;

  localparam logic [63:0] SW = 64'h1122_3344_5566_7788;
  localparam int NV = 40;
  localparam vec_t VECS [NV] = '{
    '{4'h0,1'b0,1'b1,16'd0,32'hFFFF_FFFF,64'h10,64'h0,64'hF,1'b0,8'd4},                                   // R4
    '{4'h0,1'b0,1'b0,16'd0,32'hFFFF_FFFF,64'hAAAA_AAAA_0000_0010,64'h0,64'hF,1'b0,8'd5},                  // R5
    '{4'h0,1'b1,1'b1,16'd0,32'h0,64'hFFFF_FFFF_FFFF_FFFF,64'h2,64'h1,1'b0,8'd6},                          // R6
    '{4'h1,1'b1,1'b0,16'd0,32'h0,64'h5,64'h7,64'h0000_0000_FFFF_FFFE,1'b0,8'd6},                          // R6
    '{4'h2,1'b1,1'b1,16'd0,32'h0,64'h1_0000_0001,64'h1_0000_0003,64'h4_0000_0003,1'b0,8'd6},              // R6
    '{4'h4,1'b0,1'b1,16'd0,32'h8000_0000,64'h1,64'h0,64'hFFFF_FFFF_8000_0001,1'b0,8'd4},                  // R4
    '{4'h5,1'b1,1'b1,16'd0,32'h0,64'hF0F0_F0F0_F0F0_F0F0,64'hFF00_FF00_FF00_FF00,64'hF000_F000_F000_F000,1'b0,8'd6}, // R6
    '{4'ha,1'b0,1'b0,16'd0,32'h0000_00FF,64'h1234_5678_0000_FFFF,64'h0,64'hFF00,1'b0,8'd6},               // R6
    '{4'h6,1'b0,1'b1,16'd0,32'h44,64'h1,64'h0,64'h10,1'b0,8'd7},                                          // R7
    '{4'h6,1'b0,1'b0,16'd0,32'h24,64'h1_8000_0001,64'h0,64'h10,1'b0,8'd7},                                // R7
    '{4'h7,1'b1,1'b0,16'd0,32'h0,64'hFFFF_FFFF_8000_0000,64'h4,64'h0800_0000,1'b0,8'd7},                  // R7
    '{4'hc,1'b1,1'b1,16'd0,32'h0,64'h8000_0000_0000_0000,64'h4,64'hF800_0000_0000_0000,1'b0,8'd7},        // R7
    '{4'hc,1'b1,1'b0,16'd0,32'h0,64'h8000_0000,64'h4,64'hF800_0000,1'b0,8'd7},                            // R7
    '{4'h8,1'b0,1'b1,16'd0,32'h0,64'h1,64'h0,64'hFFFF_FFFF_FFFF_FFFF,1'b0,8'd8},                          // R8
    '{4'h8,1'b0,1'b0,16'd0,32'h0,64'h5_0000_0001,64'h0,64'hFFFF_FFFF,1'b0,8'd8},                          // R8
    '{4'h8,1'b1,1'b1,16'd0,32'h0,64'h1234,64'h9,64'h1234,1'b1,8'd8},                                      // R8
    '{4'hb,1'b0,1'b1,16'd0,32'h8000_0000,64'h0,64'h0,64'hFFFF_FFFF_8000_0000,1'b0,8'd9},                  // R9
    '{4'hb,1'b1,1'b0,16'd0,32'h0,64'h3,64'hDEAD_BEEF_1234_5678,64'h1234_5678,1'b0,8'd9},                  // R9
    '{4'hb,1'b1,1'b1,16'd8,32'h0,64'h3,64'h80,64'hFFFF_FFFF_FFFF_FF80,1'b0,8'd9},                         // R9
    '{4'hb,1'b1,1'b1,16'd16,32'h0,64'h3,64'h1234_8001,64'hFFFF_FFFF_FFFF_8001,1'b0,8'd9},                 // R9
    '{4'hb,1'b1,1'b1,16'd32,32'h0,64'h3,64'h9000_0000,64'hFFFF_FFFF_9000_0000,1'b0,8'd9},                 // R9
    '{4'hb,1'b1,1'b0,16'd8,32'h0,64'h3,64'hFE,64'hFFFF_FFFE,1'b0,8'd9},                                   // R9
    '{4'hb,1'b1,1'b0,16'd32,32'h0,64'h77,64'h5,64'h77,1'b1,8'd9},                                         // R9
    '{4'hb,1'b0,1'b1,16'd8,32'h0,64'h55,64'h5,64'h55,1'b1,8'd9},                                          // R9
    '{4'hb,1'b1,1'b1,16'd4,32'h0,64'h66,64'h5,64'h66,1'b1,8'd9},                                          // R9
    '{4'hd,1'b0,1'b0,16'd0,32'd16,SW,64'h0,64'h7788,1'b0,8'd10},                                          // R10
    '{4'hd,1'b1,1'b0,16'd0,32'd16,SW,64'h0,64'h8877,1'b0,8'd10},                                          // R10
    '{4'hd,1'b1,1'b0,16'd0,32'd32,SW,64'h0,64'h8877_6655,1'b0,8'd10},                                     // R10
    '{4'hd,1'b1,1'b0,16'd0,32'd64,SW,64'h0,64'h8877_6655_4433_2211,1'b0,8'd10},                           // R10
    '{4'hd,1'b0,1'b0,16'd0,32'd32,SW,64'h0,64'h5566_7788,1'b0,8'd10},                                     // R10
    '{4'hd,1'b0,1'b0,16'd0,32'd64,SW,64'h0,SW,1'b0,8'd10},                                                // R10
    '{4'hd,1'b0,1'b1,16'd0,32'd16,SW,64'h0,64'h8877,1'b0,8'd11},                                          // R11
    '{4'hd,1'b0,1'b1,16'd0,32'd32,SW,64'h0,64'h8877_6655,1'b0,8'd11},                                     // R11
    '{4'hd,1'b0,1'b1,16'd0,32'd64,SW,64'h0,64'h8877_6655_4433_2211,1'b0,8'd11},                           // R11
    '{4'hd,1'b1,1'b1,16'd0,32'd16,SW,64'h0,SW,1'b1,8'd11},                                                // R11
    '{4'hd,1'b0,1'b0,16'd0,32'd8,SW,64'h0,SW,1'b1,8'd11},                                                 // R11
    '{4'h3,1'b1,1'b1,16'd0,32'h0,64'h99,64'h3,64'h99,1'b1,8'd12},                                         // R12
    '{4'h9,1'b1,1'b1,16'd0,32'h0,64'h98,64'h3,64'h98,1'b1,8'd12},                                         // R12
    '{4'hf,1'b0,1'b0,16'd0,32'h0,64'h97,64'h3,64'h97,1'b1,8'd12},                                         // R12
    '{4'h0,1'b1,1'b1,16'd1,32'h0,64'h96,64'h3,64'h96,1'b1,8'd12}                                          // R12
  };

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_op = v.op; in_use_reg = v.rs; in_wide = v.wd; in_offset = v.off;
    in_imm = v.imm; in_dst = v.dst; in_src = v.src;
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    vec_t va, vb;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R3 out_valid in reset", 64'(out_valid), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R3 idle after reset",
        64'({out_valid, in_ready}), 64'h1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid && out_data == VECS[i].exp && out_illegal == VECS[i].ill,
          $sformatf("R%0d vector %0d", VECS[i].req, i),
          {out_data[62:0], out_illegal}, {VECS[i].exp[62:0], VECS[i].ill});
    end

    // R2 stall with a second operation waiting
    va = '{4'h0,1'b1,1'b1,16'd0,32'h0,64'h1,64'h2,64'h3,1'b0,8'd2};
    vb = '{4'h0,1'b1,1'b1,16'd0,32'h0,64'h10,64'h10,64'h20,1'b0,8'd2};
    @(negedge clk);
    out_ready = 1'b0;
    drive(va);
    in_valid = 1'b1;
    @(negedge clk);
    drive(vb);
    chk(out_valid && out_data == 64'h3 && !in_ready, "R2 stall first", out_data, 64'h3);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid && out_data == 64'h3 && !out_illegal && !in_ready, "R2 stall hold", out_data, 64'h3);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_data == 64'h20, "R1 release takes waiting op", out_data, 64'h20);
    @(negedge clk);
    chk(!out_valid, "R1 drained empty", 64'(out_valid), 64'h0);

    // R10 opposite host order via big-endian instance
    @(negedge clk);
    drive('{4'hd,1'b0,1'b0,16'd0,32'd16,SW,64'h0,64'h0,1'b0,8'd10});
    in_valid = 1'b1;
    @(negedge clk);
    chk(be_valid && be_data == 64'h8877 && !be_illegal, "R10 BE host little conv", be_data, 64'h8877);
    drive('{4'hd,1'b1,1'b0,16'd0,32'd32,SW,64'h0,64'h0,1'b0,8'd10});
    @(negedge clk);
    in_valid = 1'b0;
    chk(be_valid && be_data == 64'h5566_7788, "R10 BE host big conv", be_data, 64'h5566_7788);
    chk(out_data == 64'h8877_6655, "R10 LE host big conv", out_data, 64'h8877_6655);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule